// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

The engine moves data for one channel once that channel has been granted a request. Each request arrives with the channel's current source address, destination address, unit count and control word on input ports. The engine captures these values when it accepts the request. It then moves data in units, one read beat followed by one write beat per unit, on a simple bus with a ready handshake. After the run it presents the updated addresses, the remaining count and the control word on a write-back port. The registers that hold the channel state sit outside the engine and take these values in.

The control word selects the unit size, a stepping mode for each of the two addresses, and whether each end of the transfer is a device or memory. A request can ask for a single unit or for the whole remaining count. When the remaining count reaches zero, the engine sets the transfer-end flag in the control word it writes back. If interrupts are enabled for the channel, it also pulses an interrupt at the same time.

Top module: `dma_xfer_engine`

## Requirements
- R1: The unit size in bytes is decoded from `ctrl_i[6:4]`: code 0 gives 8, code 1 gives 1, code 2 gives 2, code 3 gives 4 and code 4 gives 32. Codes 5, 6 and 7 give 1. The size is shown on `bus_bytes_o` during every beat.
- R2: The destination step mode is `ctrl_i[15:14]`. Mode 0 keeps the write address fixed, mode 1 adds the unit size after each unit, and mode 2 subtracts it.
- R3: The source step mode is `ctrl_i[13:12]` and uses the same encoding as R2, applied to the read address.
- R4: If a runnable request has mode 3 in either step field, `err_o` is high for exactly the one cycle after the request. In that case there are no bus beats, no write-back and no busy cycle.
- R5: Only `count_i[23:0]` is used as the count. A value of zero there means 2^24 units. A single-unit request taken from a zero count writes back 0xFFFFFF.
- R6: A request is accepted only when `ctrl_i[0]` is 1, `ctrl_i[1]` is 0 and `glb_ctl_i` equals 3'b001. Any other request is ignored: no busy, no beats and no write-back.
- R7: Each unit is one read beat at the source address, then one write beat at the destination address. The run ends with exactly one `wb_valid_o` cycle that carries the stepped addresses and the remaining count.
- R8: With `req_full_i` set, units repeat until the count is exhausted, with write-back only at the end. With it clear, exactly one unit moves.
- R9: When the remaining count written back is zero, `wb_ctrl_o` equals the captured control word with bit 1 set. Otherwise it equals the captured control word unchanged. `irq_o` pulses with that write-back when `ctrl_i[2]` was 1.
- R10: `bus_dev_o` equals `ctrl_i[9]` during read beats and `ctrl_i[8]` during write beats.
- R11: `busy_o` rises in the cycle after an accepted request and stays high through the write-back cycle. Requests made while busy are ignored.
- R12: A beat whose `bus_rdy_i` is low is held with the same address and data until it completes.
- R13: The write beat's data equals the `bus_rdata_i` value taken when the read beat of the same unit completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Granted transfer request |
| req_full_i | input | 1 | 1 runs the full remaining count, 0 runs a single unit |
| glb_ctl_i | input | 3 | Global operation control; value 001 allows runs |
| src_addr_i | input | 32 | Channel source address |
| dst_addr_i | input | 32 | Channel destination address |
| count_i | input | 32 | Channel unit count (low 24 bits used) |
| ctrl_i | input | 32 | Channel control word |
| busy_o | output | 1 | Run in progress |
| err_o | output | 1 | Illegal step mode pulse |
| irq_o | output | 1 | Transfer-end interrupt pulse |
| bus_rd_o | output | 1 | Read beat request |
| bus_wr_o | output | 1 | Write beat request |
| bus_addr_o | output | 32 | Beat address |
| bus_bytes_o | output | 6 | Beat size in bytes |
| bus_dev_o | output | 1 | Beat targets device space |
| bus_wdata_o | output | 32 | Write beat data |
| bus_rdata_i | input | 32 | Read beat data |
| bus_rdy_i | input | 1 | Beat completes this cycle |
| wb_valid_o | output | 1 | Write-back values valid |
| wb_src_o | output | 32 | Updated source address |
| wb_dst_o | output | 32 | Updated destination address |
| wb_count_o | output | 32 | Remaining unit count |
| wb_ctrl_o | output | 32 | Updated control word |

## Verification
If the step logic is wrong, the error shows up on the second beat address of a multi-unit run. Because the scoreboard compares every completed beat, the mismatch is reported within two beats of the faulty unit. A count that is loaded or decremented wrongly shows up as an extra beat or a missing beat before the write-back. It also shows up as a wrong `wb_count_o` or a wrong transfer-end bit at the single write-back. A state machine stuck in a beat shows up as a busy signal that never falls, or as an event the scoreboard did not expect.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  localparam int CTL_EN     = 0;
  localparam int CTL_TE     = 1;
  localparam int CTL_IE     = 2;
  localparam int CTL_SZ_LO  = 4;
  localparam int CTL_RES_LO = 8;
  localparam int CTL_SM_LO  = 12;
  localparam int CTL_DM_LO  = 14;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_BAD   = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD,
    S_WR,
    S_WB
  } state_e;

  function automatic logic [5:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd2:    return 6'd2;
      3'd3:    return 6'd4;
      3'd4:    return 6'd32;
      default: return 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_xfer_pkg::*;
#(
  parameter int CTLW = 32,
  parameter int GLBW = 3
) (
  input  logic [CTLW-1:0] ctl_i,
  input  logic [GLBW-1:0] glb_i,
  output logic [5:0]      bytes_o,
  output amode_e          src_mode_o,
  output amode_e          dst_mode_o,
  output logic            src_dev_o,
  output logic            dst_dev_o,
  output logic            runnable_o,
  output logic            illegal_o
);
  localparam logic [GLBW-1:0] GLB_RUN = GLBW'(1);

  logic unused_ctl;
  assign unused_ctl = ^{ctl_i[CTLW-1:16], ctl_i[CTL_RES_LO+3:CTL_RES_LO+2], ctl_i[7], ctl_i[3]};

  assign bytes_o    = unit_bytes(ctl_i[CTL_SZ_LO+:3]);
  assign src_mode_o = amode_e'(ctl_i[CTL_SM_LO+:2]);
  assign dst_mode_o = amode_e'(ctl_i[CTL_DM_LO+:2]);
  // resource bit 1 marks the read side as device, bit 0 the write side
  assign src_dev_o  = ctl_i[CTL_RES_LO+1];
  assign dst_dev_o  = ctl_i[CTL_RES_LO];
  assign runnable_o = ctl_i[CTL_EN] && !ctl_i[CTL_TE] && (glb_i == GLB_RUN);
  assign illegal_o  = (src_mode_o == AM_BAD) || (dst_mode_o == AM_BAD);
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  amode_e        mode_i,
  input  logic [5:0]    bytes_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] step;
  assign step = {{(AW-6){1'b0}}, bytes_i};

  always_comb begin
    case (mode_i)
      AM_INC:  addr_o = addr_i + step;
      AM_DEC:  addr_o = addr_i - step;
      default: addr_o = addr_i;
    endcase
  end
endmodule

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int CW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW:0]   remain_o,
  output logic          last_o
);
  localparam logic [CW:0] FULL_LEN = {1'b1, {CW{1'b0}}};
  localparam logic [CW:0] ONE      = (CW+1)'(1);

  logic [CW:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (load_val_i == '0) ? FULL_LEN : {1'b0, load_val_i};
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign remain_o = cnt_q;
  assign last_o   = (cnt_q == ONE);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RW   = 32,
  parameter int CW   = 24,
  parameter int CTLW = 32,
  parameter int GLBW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            req_full_i,
  input  logic [GLBW-1:0] glb_ctl_i,
  input  logic [AW-1:0]   src_addr_i,
  input  logic [AW-1:0]   dst_addr_i,
  input  logic [RW-1:0]   count_i,
  input  logic [CTLW-1:0] ctrl_i,
  output logic            busy_o,
  output logic            err_o,
  output logic            irq_o,
  output logic            bus_rd_o,
  output logic            bus_wr_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [5:0]      bus_bytes_o,
  output logic            bus_dev_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  input  logic            bus_rdy_i,
  output logic            wb_valid_o,
  output logic [AW-1:0]   wb_src_o,
  output logic [AW-1:0]   wb_dst_o,
  output logic [RW-1:0]   wb_count_o,
  output logic [CTLW-1:0] wb_ctrl_o
);
  localparam int NSIDE = 2; // 0: source, 1: destination

  state_e          state_q, state_d;
  logic [AW-1:0]   src_q, dst_q;
  logic [CTLW-1:0] ctl_q;
  logic [DW-1:0]   data_q;
  logic            full_q, err_q;

  logic unused_cnt;
  assign unused_cnt = ^count_i[RW-1:CW];

  // decode the live word while idle, the captured word while running
  logic [CTLW-1:0] cfg_ctl;
  logic [5:0]      bytes;
  amode_e          src_mode, dst_mode;
  logic            src_dev, dst_dev, runnable, illegal;

  assign cfg_ctl = (state_q == S_IDLE) ? ctrl_i : ctl_q;

  dma_cfg_decode #(.CTLW(CTLW), .GLBW(GLBW)) u_dec (
    .ctl_i      (cfg_ctl),
    .glb_i      (glb_ctl_i),
    .bytes_o    (bytes),
    .src_mode_o (src_mode),
    .dst_mode_o (dst_mode),
    .src_dev_o  (src_dev),
    .dst_dev_o  (dst_dev),
    .runnable_o (runnable),
    .illegal_o  (illegal)
  );

  logic [AW-1:0] side_cur [NSIDE];
  logic [AW-1:0] side_nxt [NSIDE];
  amode_e        side_mode[NSIDE];

  assign side_cur[0]  = src_q;
  assign side_cur[1]  = dst_q;
  assign side_mode[0] = src_mode;
  assign side_mode[1] = dst_mode;

  for (genvar g = 0; g < NSIDE; g++) begin : g_step
    dma_addr_step #(.AW(AW)) u_step (
      .addr_i  (side_cur[g]),
      .mode_i  (side_mode[g]),
      .bytes_i (bytes),
      .addr_o  (side_nxt[g])
    );
  end

  logic idle, accept, abort, rd_fire, wr_fire;
  assign idle    = (state_q == S_IDLE);
  assign accept  = idle && req_i && runnable && !illegal;
  assign abort   = idle && req_i && runnable && illegal;
  assign rd_fire = (state_q == S_RD) && bus_rdy_i;
  assign wr_fire = (state_q == S_WR) && bus_rdy_i;

  logic [CW:0] remain;
  logic        cnt_last;

  dma_unit_counter #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (count_i[CW-1:0]),
    .dec_i      (wr_fire),
    .remain_o   (remain),
    .last_o     (cnt_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept) state_d = S_RD;
      S_RD:   if (bus_rdy_i) state_d = S_WR;
      S_WR:   if (bus_rdy_i) state_d = (cnt_last || !full_q) ? S_WB : S_RD;
      S_WB:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      ctl_q   <= '0;
      data_q  <= '0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= abort;
      if (accept) begin
        src_q  <= src_addr_i;
        dst_q  <= dst_addr_i;
        ctl_q  <= ctrl_i;
        full_q <= req_full_i;
      end
      if (rd_fire) data_q <= bus_rdata_i;
      if (wr_fire) begin
        src_q <= side_nxt[0];
        dst_q <= side_nxt[1];
      end
    end
  end

  logic done;
  assign done = (remain == '0);

  assign busy_o      = !idle;
  assign err_o       = err_q;
  assign bus_rd_o    = (state_q == S_RD);
  assign bus_wr_o    = (state_q == S_WR);
  assign bus_addr_o  = bus_wr_o ? dst_q : src_q;
  assign bus_dev_o   = bus_wr_o ? dst_dev : src_dev;
  assign bus_bytes_o = bytes;
  assign bus_wdata_o = data_q;

  assign wb_valid_o = (state_q == S_WB);
  assign wb_src_o   = src_q;
  assign wb_dst_o   = dst_q;
  assign wb_count_o = {{(RW-CW){1'b0}}, remain[CW-1:0]};
  assign wb_ctrl_o  = ctl_q | (CTLW'(done) << CTL_TE);
  assign irq_o      = wb_valid_o && done && ctl_q[CTL_IE];
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RW   = 32,
  parameter int CTLW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            err_o,
  input logic            irq_o,
  input logic            bus_rd_o,
  input logic            bus_wr_o,
  input logic            bus_rdy_i,
  input logic [AW-1:0]   bus_addr_o,
  input logic [5:0]      bus_bytes_o,
  input logic [DW-1:0]   bus_wdata_o,
  input logic            wb_valid_o,
  input logic [RW-1:0]   wb_count_o,
  input logic [CTLW-1:0] wb_ctrl_o
);
  p_beat_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  p_wb_after_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(bus_wr_o && bus_rdy_i));

  p_wb_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);

  p_busy_cover_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o || wb_valid_o) |-> busy_o);

  p_hold_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_rdy_i) |=> (bus_rd_o && $stable(bus_addr_o)));

  p_hold_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && !bus_rdy_i) |=> (bus_wr_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  p_te_on_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_count_o == '0) |-> wb_ctrl_o[1]);

  p_irq_with_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (wb_valid_o && wb_ctrl_o[2] && wb_count_o == '0));

  p_err_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && !bus_rd_o && !wb_valid_o));

  p_size_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> ($countones(bus_bytes_o) == 1));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
  .AW(AW), .DW(DW), .RW(RW), .CTLW(CTLW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .irq_o       (irq_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .bus_rdy_i   (bus_rdy_i),
  .bus_addr_o  (bus_addr_o),
  .bus_bytes_o (bus_bytes_o),
  .bus_wdata_o (bus_wdata_o),
  .wb_valid_o  (wb_valid_o),
  .wb_count_o  (wb_count_o),
  .wb_ctrl_o   (wb_ctrl_o)
);

// File: tb/sim_dma_xfer_engine.sv
`timescale 1ns/100ps
module sim_dma_xfer_engine;
  localparam logic [31:0] KEY = 32'h5A5A_C3C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req = 1'b0, req_full = 1'b0, rdy = 1'b1;
  logic [2:0]  glb = 3'b001;
  logic [31:0] m_src = '0, m_dst = '0, m_cnt = '0, m_ctl = '0;
  logic        busy, err, irq, rd, wr, dev, wbv;
  logic [31:0] addr, wdata, rdata, wb_src, wb_dst, wb_cnt, wb_ctl;
  logic [5:0]  bytes;

  assign rdata = addr ^ KEY;

  dma_xfer_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_full_i(req_full),
    .glb_ctl_i(glb), .src_addr_i(m_src), .dst_addr_i(m_dst),
    .count_i(m_cnt), .ctrl_i(m_ctl), .busy_o(busy), .err_o(err),
    .irq_o(irq), .bus_rd_o(rd), .bus_wr_o(wr), .bus_addr_o(addr),
    .bus_bytes_o(bytes), .bus_dev_o(dev), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_rdy_i(rdy), .wb_valid_o(wbv),
    .wb_src_o(wb_src), .wb_dst_o(wb_dst), .wb_count_o(wb_cnt),
    .wb_ctrl_o(wb_ctl)
  );

  int total = 0, fails = 0, cycles = 0;
  bit stall = 1'b0;
  string cur_tag = "R6";

  typedef struct {
    int kind; // 0 read beat, 1 write beat, 2 write-back
    logic [31:0] a, b, c, d, e;
  } ev_t;
  ev_t q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "R11", "watchdog expired", 32'(cycles), 32'd150000);
      finish_run();
    end
  end

  int scnt = 0;
  always @(negedge clk) begin
    scnt++;
    rdy = stall ? ((scnt % 3) != 0) : 1'b1;
  end

  // scoreboard monitor
  always begin
    @(negedge clk);
    #1;
    if (rst_n && ((rd && rdy) || (wr && rdy) || wbv)) begin
      int k;
      ev_t x;
      k = wbv ? 2 : (wr ? 1 : 0);
      if (q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected event kind", 32'(k), 32'hFFFF_FFFF);
      end else begin
        x = q.pop_front();
        chk(x.kind == k, "R7", "event order", 32'(k), 32'(x.kind));
        if (x.kind == k) begin
          case (k)
            0: begin
              chk(addr == x.a, "R3", "read address", addr, x.a);
              chk(32'(dev) == x.b, "R10", "read device flag", 32'(dev), x.b);
              chk(32'(bytes) == x.c, "R1", "read size", 32'(bytes), x.c);
            end
            1: begin
              chk(addr == x.a, "R2", "write address", addr, x.a);
              chk(32'(dev) == x.b, "R10", "write device flag", 32'(dev), x.b);
              chk(wdata == x.c, "R13", "write data", wdata, x.c);
              chk(32'(bytes) == x.d, "R1", "write size", 32'(bytes), x.d);
            end
            default: begin
              chk(wb_src == x.a, "R7", "wb source", wb_src, x.a);
              chk(wb_dst == x.b, "R7", "wb destination", wb_dst, x.b);
              chk(wb_cnt == x.c, "R5", "wb count", wb_cnt, x.c);
              chk(wb_ctl == x.d, "R9", "wb control", wb_ctl, x.d);
              chk(32'(irq) == x.e, "R9", "interrupt", 32'(irq), x.e);
            end
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] exp_bytes(input logic [2:0] code);
    case (code)
      3'd0: return 32'd8;
      3'd2: return 32'd2;
      3'd3: return 32'd4;
      3'd4: return 32'd32;
      default: return 32'd1;
    endcase
  endfunction

  function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m,
                                       input logic [31:0] b);
    case (m)
      2'd1: return a + b;
      2'd2: return a - b;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] mk_ctl(input logic [1:0] dm, input logic [1:0] sm,
                                         input logic [3:0] res, input logic [2:0] sz,
                                         input logic ie);
    return {16'h0, dm, sm, res, 1'b0, sz, 1'b0, ie, 1'b0, 1'b1};
  endfunction

  function automatic void push(input int k, input logic [31:0] a, b, c, d, e);
    ev_t x;
    x.kind = k; x.a = a; x.b = b; x.c = c; x.d = d; x.e = e;
    q.push_back(x);
  endfunction

  task automatic run(input bit full, input bit poke);
    logic [31:0] s, d, ct, b, n, units, rem;
    int g;
    s  = m_src; d = m_dst; ct = m_ctl;
    b  = exp_bytes(ct[6:4]);
    n  = (m_cnt[23:0] == 24'd0) ? 32'h0100_0000 : {8'h0, m_cnt[23:0]};
    units = full ? n : 32'd1;
    for (int i = 0; i < int'(units); i++) begin
      push(0, s, {31'd0, ct[9]}, b, 0, 0);
      push(1, d, {31'd0, ct[8]}, s ^ KEY, b, 0);
      s = step(s, ct[13:12], b);
      d = step(d, ct[15:14], b);
    end
    rem = n - units;
    if (rem == 0) ct = ct | 32'h2;
    push(2, s, d, rem, ct, {31'd0, (rem == 0) && ct[2]});
    @(negedge clk); req = 1'b1; req_full = full;
    @(negedge clk); req = 1'b0;
    #1 chk(busy == 1'b1, "R11", "busy after accept", 32'(busy), 32'd1);
    if (poke) begin
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
    end
    g = 0;
    while (busy && g < 5000) begin
      @(negedge clk); #1; g++;
    end
    @(negedge clk); #1;
    chk(q.size() == 0, full ? "R8" : "R7", "pending events", 32'(q.size()), 32'd0);
    m_src = s; m_dst = d; m_cnt = rem; m_ctl = ct;
  endtask

  task automatic ignored(input string tag);
    cur_tag = tag;
    @(negedge clk); req = 1'b1; req_full = 1'b1;
    @(negedge clk); req = 1'b0;
    #1 chk(busy == 1'b0, tag, "busy on ignored request", 32'(busy), 32'd0);
    repeat (4) @(negedge clk);
    #1 chk(busy == 1'b0 && err == 1'b0, tag, "idle after ignored request",
           {30'd0, busy, err}, 32'd0);
  endtask

  task automatic bad_mode();
    cur_tag = "R4";
    @(negedge clk); req = 1'b1; req_full = 1'b0;
    @(negedge clk); #1;
    chk(err == 1'b1, "R4", "error pulse", 32'(err), 32'd1);
    chk(busy == 1'b0, "R4", "no busy on error", 32'(busy), 32'd0);
    req = 1'b0;
    @(negedge clk); #1;
    chk(err == 1'b0, "R4", "error one cycle", 32'(err), 32'd0);
    repeat (3) @(negedge clk);
    #1 chk(busy == 1'b0, "R4", "still idle", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({busy, err, irq, rd, wr, wbv} == 6'd0, "R11", "reset outputs",
        {26'd0, busy, err, irq, rd, wr, wbv}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 single unit, then R8/R9 full run to end with interrupt
    m_src = 32'h1000; m_dst = 32'h2000; m_cnt = 32'd3;
    m_ctl = mk_ctl(2'd1, 2'd1, 4'h0, 3'd3, 1'b1);
    cur_tag = "R7";
    run(1'b0, 1'b0);
    cur_tag = "R8";
    run(1'b1, 1'b0);

    // R6: transfer-end already set, channel disabled, global control wrong
    ignored("R6");
    m_ctl = mk_ctl(2'd1, 2'd1, 4'h0, 3'd3, 1'b1) & ~32'h1;
    m_cnt = 32'd2;
    ignored("R6");
    m_ctl = mk_ctl(2'd1, 2'd1, 4'h0, 3'd3, 1'b1);
    glb = 3'b011;
    ignored("R6");
    glb = 3'b001;

    // R1/R2/R3/R10: every size code, fixed destination, decrementing source
    for (int code = 0; code < 8; code++) begin
      m_src = 32'h4000 + 32'(code * 64); m_dst = 32'h8000; m_cnt = 32'd1;
      m_ctl = mk_ctl(2'd0, 2'd2, 4'h3, 3'(code), 1'b0);
      cur_tag = "R1";
      run(1'b1, 1'b0);
    end

    // R4: illegal source mode, then illegal destination mode
    m_src = 32'h100; m_dst = 32'h200; m_cnt = 32'd4;
    m_ctl = mk_ctl(2'd1, 2'd3, 4'h0, 3'd1, 1'b1);
    bad_mode();
    m_ctl = mk_ctl(2'd3, 2'd1, 4'h0, 3'd1, 1'b1);
    bad_mode();

    // R5: zero count with upper garbage means 2^24 units
    m_src = 32'hA000; m_dst = 32'hB000; m_cnt = 32'hAB00_0000;
    m_ctl = mk_ctl(2'd2, 2'd1, 4'h1, 3'd0, 1'b1);
    cur_tag = "R5";
    run(1'b0, 1'b0);

    // R12/R11: stalled bus, full run, request poked while busy
    stall = 1'b1;
    m_src = 32'hC000; m_dst = 32'hD000; m_cnt = 32'h7700_0004;
    m_ctl = mk_ctl(2'd2, 2'd0, 4'h2, 3'd4, 1'b0);
    cur_tag = "R11";
    run(1'b1, 1'b1);
    stall = 1'b0;

    // R8: multi-unit run, 2-byte units, both addresses incrementing
    m_src = 32'h0; m_dst = 32'h10; m_cnt = 32'd5;
    m_ctl = mk_ctl(2'd1, 2'd1, 4'h0, 3'd2, 1'b0);
    cur_tag = "R8";
    run(1'b1, 1'b0);

    finish_run();
  end
endmodule